// File: doc/BRIEF.md
# Serial Programming Command Interface

This block is the device-side end of a four-wire link through which an external programmer reaches the on-chip memories. The programmer raises a framing line, then clocks a 32-bit command into the serial data input, most significant bit first. The three input wires are sampled by the block's own system clock through a synchroniser. A command is taken only once all 32 bits have arrived. The block splits the word into an operation code, a 16-bit address and a data byte, and presents one request on a parallel memory port. The request stays up until the memory answers with a done pulse.

The serial output carries two things. A command whose first bit is 1 is a write, a page write or an erase. For such a command the output is pulled low as soon as that first bit has been taken. It stays low until the memory reports completion, so the programmer can poll it before sending the next command. A read command returns its byte on the same wire: the byte appears after the memory answers and is shifted out during the next frame. Clock edges that arrive while a request is outstanding are discarded.

Top module: `sprog_if`

## Requirements
- R1: After reset the serial output is high and no memory request is raised.
- R2: A command word is 32 bits sent most significant bit first on rising serial clock edges while the framing line is high. Bits 31:24 are the operation code, bits 23:8 the address and bits 7:0 the data byte. The address and data appear unchanged on the memory port together with a request that rises after the 32nd edge.
- R3: Operation codes map to memory operations as follows: 0x40 gives read (port code 0), 0x80 gives byte write (1), 0x90 gives page write (2) and 0xA0 gives erase (3).
- R4: Any other operation code raises no request, and once the frame is complete the serial output is high.
- R5: When the first bit of a frame is 1, the serial output goes low after that first rising edge and before the second. When the first bit is 0, the output stays high.
- R6: While a write-class request is outstanding the serial output stays low and the request, address, data and operation hold steady. The cycle after done is seen, the request falls and the output is released high.
- R7: Lowering the framing line before the 32nd edge discards the partial command: no request is raised, the output returns high, and the next frame is counted from its first bit.
- R8: Serial clock edges while the framing line is low are not shifted in.
- R9: Serial clock edges while a request is outstanding are ignored: the outstanding request and its fields stay unchanged, and no second request follows.
- R10: When a read completes, bit 7 of the returned byte is on the serial output. Each rising edge of the following frame brings out the next lower bit. After eight edges the output is high.
- R11: Edges beyond the 32nd in one frame are ignored and issue no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progLoad | input | 1 | Framing line from the programmer, high during a command |
| progClk | input | 1 | Serial clock from the programmer |
| progDin | input | 1 | Serial command data, MSB first |
| progDout | output | 1 | Serial output: busy indicator (low) or read-back data |
| memReq | output | 1 | Memory request, held until memDone |
| memOp | output | 2 | 0 read, 1 byte write, 2 page write, 3 erase |
| memAddr | output | ADDR_W | Memory address of the request |
| memWdata | output | DATA_W | Write data of the request |
| memRdata | input | DATA_W | Read data, valid with memDone |
| memDone | input | 1 | One-cycle completion pulse from the memory |

## Verification
Some faults lose or misplace a bit in the shift register or the bit counter. They show at the port only once the frame ends: a wrong operation code, wrong address or wrong data, or a request that never rises, within a few system clocks of the 32nd edge. A wrong busy state shows on the serial output during the first bit period of a write frame, or in the cycle after done. Read-back errors show bit by bit, one serial edge at a time, in the frame that follows the read.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  // Operation code field width; its codes are decoded below.
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_READ    = 8'h40;
  localparam logic [OPC_W-1:0] OPC_BYTE_WR = 8'h80;
  localparam logic [OPC_W-1:0] OPC_PAGE_WR = 8'h90;
  localparam logic [OPC_W-1:0] OPC_ERASE   = 8'hA0;

  typedef enum logic [1:0] {
    MEM_READ    = 2'd0,
    MEM_BYTE_WR = 2'd1,
    MEM_PAGE_WR = 2'd2,
    MEM_ERASE   = 2'd3
  } memOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic frameClr;  // restart the bit count
    logic shiftEn;   // accept one serial bit
    logic loadRd;    // capture read data for shifting out
  } dpStrobe_t;
endpackage

// File: rtl/sprog_dp.sv
module sprog_dp
  import sprog_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W      = OPC_W + ADDR_W + DATA_W,
  localparam int CNT_W      = $clog2(CMD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldIn,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] rdData,
  output logic              ldHigh,
  output logic              sclkRise,
  output logic              sdiBit,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              rdMsb
);
  // Synchroniser chains; SYNC_STAGES must be 2 or more.
  logic [SYNC_STAGES-1:0] ldSync, sclkSync, sdiSync;
  logic                   sclkPrev;
  logic [DATA_W-1:0]      rdSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldSync   <= '0;
      sclkSync <= '0;
      sdiSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      ldSync   <= {ldSync[SYNC_STAGES-2:0], ldIn};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdiIn};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign ldHigh   = ldSync[SYNC_STAGES-1];
  assign sdiBit   = sdiSync[SYNC_STAGES-1];
  assign sclkRise = sclkSync[SYNC_STAGES-1] & ~sclkPrev;

  // Command shift register and bit counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      cmdWord <= '0;
    end else if (strb.frameClr) begin
      bitCnt <= '0;
    end else if (strb.shiftEn) begin
      cmdWord <= {cmdWord[CMD_W-2:0], sdiBit};
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // Read-back shifter; ones fill in behind the data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSr <= '1;
    end else if (strb.loadRd) begin
      rdSr <= rdData;
    end else if (strb.shiftEn) begin
      rdSr <= {rdSr[DATA_W-2:0], 1'b1};
    end
  end

  assign rdMsb = rdSr[DATA_W-1];

  // R11
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CMD_W));

  // R7
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameClr |=> (bitCnt == '0));
endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
  import sprog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int CMD_W = OPC_W + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(CMD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldHigh,
  input  logic              sclkRise,
  input  logic              sdiBit,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              memDone,
  output dpStrobe_t         strb,
  output logic              busyLow,
  output logic              memReq,
  output memOp_e            memOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic             lastBit;
  logic             cmdReady;
  logic             decValid;
  memOp_e           decOp;
  logic [OPC_W-1:0] opc;

  assign strb.frameClr = ~ldHigh;
  assign strb.shiftEn  = ldHigh & sclkRise & ~memReq & (bitCnt < CNT_W'(CMD_W));
  assign strb.loadRd   = memReq & memDone & (memOp == MEM_READ);
  assign lastBit       = strb.shiftEn & (bitCnt == CNT_W'(CMD_W - 1));

  assign opc = cmdWord[CMD_W-1 -: OPC_W];

  always_comb begin
    decValid = 1'b1;
    decOp    = MEM_READ;
    case (opc)
      OPC_READ:    decOp = MEM_READ;
      OPC_BYTE_WR: decOp = MEM_BYTE_WR;
      OPC_PAGE_WR: decOp = MEM_PAGE_WR;
      OPC_ERASE:   decOp = MEM_ERASE;
      default:     decValid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReady <= 1'b0;
      busyLow  <= 1'b0;
      memReq   <= 1'b0;
      memOp    <= MEM_READ;
      memAddr  <= '0;
      memWdata <= '0;
    end else begin
      cmdReady <= lastBit;
      // A leading 1 marks a write-class command: show busy at once.
      if (strb.shiftEn && bitCnt == '0 && sdiBit) busyLow <= 1'b1;
      // A frame dropped before completion releases the busy line.
      if (!ldHigh && !memReq && !cmdReady) busyLow <= 1'b0;
      if (cmdReady) begin
        if (decValid) begin
          memReq   <= 1'b1;
          memOp    <= decOp;
          memAddr  <= cmdWord[DATA_W +: ADDR_W];
          memWdata <= cmdWord[DATA_W-1:0];
        end else begin
          busyLow <= 1'b0;
        end
      end
      if (memReq && memDone) begin
        memReq  <= 1'b0;
        busyLow <= 1'b0;
      end
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> memReq && $stable(memAddr) && $stable(memOp) && $stable(memWdata));

  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memDone |=> !memReq && !busyLow);

  // R5
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memOp != MEM_READ |-> busyLow);
endmodule

// File: rtl/sprog_if.sv
module sprog_if
  import sprog_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W      = OPC_W + ADDR_W + DATA_W,
  localparam int CNT_W      = $clog2(CMD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progLoad,
  input  logic              progClk,
  input  logic              progDin,
  output logic              progDout,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);
  dpStrobe_t        strb;
  logic             ldHigh, sclkRise, sdiBit, rdMsb, busyLow;
  logic [CNT_W-1:0] bitCnt;
  logic [CMD_W-1:0] cmdWord;
  memOp_e           memOpE;

  sprog_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ldIn(progLoad), .sclkIn(progClk), .sdiIn(progDin),
    .strb(strb), .rdData(memRdata), .ldHigh(ldHigh), .sclkRise(sclkRise),
    .sdiBit(sdiBit), .bitCnt(bitCnt), .cmdWord(cmdWord), .rdMsb(rdMsb)
  );

  sprog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ldHigh(ldHigh), .sclkRise(sclkRise), .sdiBit(sdiBit),
    .bitCnt(bitCnt), .cmdWord(cmdWord), .memDone(memDone), .strb(strb),
    .busyLow(busyLow), .memReq(memReq), .memOp(memOpE), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  assign memOp    = memOpE;
  assign progDout = ~busyLow & rdMsb;
endmodule

// File: tb/sprog_if_tb.sv
module sprog_if_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progLoad = 1'b0, progClk = 1'b0, progDin = 1'b0;
  logic        progDout, memReq, memDone = 1'b0;
  logic [1:0]  memOp;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata = 8'h00;
  int          checks = 0, errors = 0;
  localparam int H = 6;

  always #4 clk = ~clk;

  sprog_if u_dut (
    .clk(clk), .rstN(rstN), .progLoad(progLoad), .progClk(progClk), .progDin(progDin),
    .progDout(progDout), .memReq(memReq), .memOp(memOp), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memDone(memDone)
  );

  // {command, read data, request expected, op expected}
  localparam logic [42:0] VECS [6] = '{
    {32'h900C105A, 8'h00, 1'b1, 2'd2},
    {32'h800123A5, 8'h00, 1'b1, 2'd1},
    {32'hA00C0000, 8'h00, 1'b1, 2'd3},
    {32'h400C2000, 8'hC3, 1'b1, 2'd0},
    {32'h12345678, 8'h00, 1'b0, 2'd0},
    {32'hFFFFFFFF, 8'h00, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    progLoad = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) progDin = w[31-i];
      repeat (H) @(negedge clk);
      progClk = 1'b1;
      repeat (H) @(negedge clk);
      progClk = 1'b0;
    end
  endtask

  task automatic endFrame();
    @(negedge clk) progLoad = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseDone(input logic [7:0] rd);
    @(negedge clk) begin memDone = 1'b1; memRdata = rd; end
    @(negedge clk) memDone = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 dout", progDout, 1);
    chk("R1 req", memReq, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R2 R3 R4 R6
    for (int i = 0; i < 6; i++) begin
      logic [31:0] c;
      logic [7:0]  rd;
      logic        rq;
      logic [1:0]  op;
      {c, rd, rq, op} = VECS[i];
      sendBits(c, 32);
      repeat (8) @(negedge clk);
      chk(rq ? "R2 req" : "R4 req", memReq, rq);
      if (rq) begin
        chk("R3 op", memOp, op);
        chk("R2 addr", memAddr, c[23:8]);
        chk("R2 data", memWdata, c[7:0]);
        chk("R6 busy", progDout, op == 2'd0);
        pulseDone(rd);
        chk("R6 req fall", memReq, 0);
        chk("R6 dout after done", progDout, (op == 2'd0) ? rd[7] : 1'b1);
      end else begin
        chk("R4 dout", progDout, 1);
      end
      endFrame();
    end

    // R5: busy shows between first and second edge
    sendBits(32'h9001AA00, 1);
    chk("R5 write first bit", progDout, 0);
    sendBits(32'h9001AA00 << 1, 31);
    repeat (8) @(negedge clk);
    chk("R5 req", memReq, 1);
    pulseDone(8'h00);
    endFrame();
    sendBits(32'h40000000, 1);
    chk("R5 read first bit", progDout, 1);
    endFrame();

    // R7: aborted frame
    sendBits(32'h90FFFF00, 5);
    chk("R7 busy mid frame", progDout, 0);
    endFrame();
    chk("R7 dout released", progDout, 1);
    chk("R7 no req", memReq, 0);
    sendBits(32'h800AB0CD, 32);
    repeat (8) @(negedge clk);
    chk("R7 op", memOp, 1);
    chk("R7 addr", memAddr, 16'h0AB0);
    chk("R7 data", memWdata, 8'hCD);
    pulseDone(8'h00);
    endFrame();

    // R8: edges with framing line low
    progDin = 1'b1;
    for (int k = 0; k < 10; k++) begin
      repeat (H) @(negedge clk); progClk = 1'b1;
      repeat (H) @(negedge clk); progClk = 1'b0;
    end
    chk("R8 no req", memReq, 0);
    sendBits(32'h400C5500, 32);
    repeat (8) @(negedge clk);
    chk("R8 op", memOp, 0);
    chk("R8 addr", memAddr, 16'h0C55);
    chk("R8 dout", progDout, 1);
    pulseDone(8'h80);
    chk("R8 dout after read", progDout, 1);
    endFrame();

    // R9: edges ignored while request outstanding
    sendBits(32'h900C4011, 32);
    repeat (8) @(negedge clk);
    chk("R9 req", memReq, 1);
    endFrame();
    sendBits(32'h80000122, 32);
    repeat (8) @(negedge clk);
    chk("R9 addr kept", memAddr, 16'h0C40);
    chk("R9 op kept", memOp, 2);
    chk("R9 data kept", memWdata, 8'h11);
    chk("R9 busy kept", progDout, 0);
    endFrame();
    pulseDone(8'h00);
    chk("R9 req fall", memReq, 0);
    chk("R9 dout released", progDout, 1);
    repeat (8) @(negedge clk);
    chk("R9 no second req", memReq, 0);

    // R11: extra edges in one frame
    sendBits(32'h80000233, 32);
    repeat (8) @(negedge clk);
    chk("R11 req", memReq, 1);
    pulseDone(8'h00);
    sendBits(32'hA0000000, 8);
    repeat (8) @(negedge clk);
    chk("R11 no extra req", memReq, 0);
    endFrame();

    // R10: read-back during following frame
    sendBits(32'h400C7700, 32);
    repeat (8) @(negedge clk);
    chk("R10 req", memReq, 1);
    pulseDone(8'hA6);
    endFrame();
    chk("R10 bit7", progDout, 1'b1);
    for (int k = 1; k < 8; k++) begin
      logic [7:0] v;
      v = 8'hA6;
      sendBits(32'h0, 1);
      chk("R10 bit", progDout, v[7-k]);
    end
    sendBits(32'h0, 1);
    chk("R10 after byte", progDout, 1);
    endFrame();

    summary();
    $finish;
  end
endmodule